// File: doc/BRIEF.md
# Linked descriptor DMA parameter sequencer

The sequencer keeps a small RAM of descriptor slots and runs one of them, the active slot, through a transfer with three nested counts. Each descriptor has eight 32-bit words. The innermost unit is an array of A-count bytes. B-count arrays make a frame, and C-count frames make the whole transfer. Each array is sent to a downstream transfer port as one request: source address, destination address and byte count. The port is valid/ready. `req_valid` stays high, and source, destination and byte count stay unchanged, until a cycle with `req_ready` high. After the handshake the sequencer waits for a one-cycle `req_done` pulse. It never has a second request open.

An event trigger moves either one array or one whole frame, depending on the sync-dimension option of the descriptor. After each array, the sequencer writes the advanced addresses and the decremented counts back into the active slot. When the last array of the last frame completes, the sequencer does one of three things:
- copies the slot named by the descriptor's link field into the active slot;
- loads a null descriptor, when the link value is the "no link" code;
- changes nothing, when the descriptor is marked static.

Completion flags, a chain pulse and a 6-bit completion code tell the rest of the chip which channel finished. Software fills the RAM through a simple word-write port while the sequencer is idle.

Top module: `link_desc_seq`

## Requirements
- R1: After reset, `req_valid`, `fin_irq`, `mid_irq`, `chain_go` and `fault` are low, and every descriptor word is zero, so the active slot reads as null.
- R2: A request carries word 1 of the active slot as source, word 3 as destination and word 2 bits 15:0 (the A count) as the byte count. Word 2 bits 31:16 hold the B count. While `req_valid` is high and `req_ready` is low, the request and its fields stay unchanged.
- R3: Only one request is open at a time, from its handshake to `req_done`. Triggers that arrive while the sequencer is busy are held as a single pending bit, which is served after the current unit completes. Further triggers that arrive during the same busy period are merged into that bit.
- R4: With option bit 2 clear, one trigger issues one array request. With option bit 2 set, one trigger issues requests back to back, without further triggers, until the current frame ends.
- R5: After an array with B count above 1, the B count drops by one and the addresses advance by the sign-extended B strides. Word 4 holds the source stride in bits 15:0 and the destination stride in bits 31:16. After an array with B count 1, these changes apply:
  - the C count in word 7 bits 15:0 drops by one;
  - the B count reloads from word 5 bits 31:16;
  - the addresses advance by the C strides in word 6, laid out like word 4.
- R6: With option bit 0 set, the source address stays constant. With option bit 1 set, the destination address stays constant.
- R7: One cycle after `req_done`, `evt_code` equals option bits 17:12. On the final array (B count 1 and C count 1), `fin_irq` equals option bit 20 and `chain_go` equals option bit 22. On any other array that ends a trigger's unit, `mid_irq` equals option bit 21 and `chain_go` equals option bit 23. All other completions leave the flags and `chain_go` low.
- R8: At final completion of a non-static descriptor, when word 5 bits 15:0 are not 0xFFFF, the slot those bits name (low index bits) is copied into the active slot (parameter `ACT_SLOT`, default 0).
- R9: With option bit 3 set, final completion leaves the active slot unchanged.
- R10: A link value of 0xFFFF loads the null descriptor: all zeros except word 5, which is 0x0000FFFF. A trigger on a slot whose A, B or C count is zero raises a one-cycle `fault` and issues no request.
- R11: A `cfg_we` cycle writes `cfg_wdata` to slot `cfg_addr[5:3]`, word `cfg_addr[2:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig | input | 1 | Event trigger, one pulse per event |
| cfg_we | input | 1 | Descriptor word write enable |
| cfg_addr | input | 6 | Slot (bits 5:3) and word (bits 2:0) |
| cfg_wdata | input | 32 | Write data |
| req_valid | output | 1 | Request valid |
| req_ready | input | 1 | Request accepted by the transfer port |
| req_src | output | 32 | Source address of the array |
| req_dst | output | 32 | Destination address of the array |
| req_bytes | output | 16 | Byte count of the array |
| req_done | input | 1 | Pulse: the accepted request has completed |
| fin_irq | output | 1 | Pulse: final completion flag |
| mid_irq | output | 1 | Pulse: intermediate completion flag |
| chain_go | output | 1 | Pulse: chain trigger for channel `evt_code` |
| evt_code | output | 6 | Completion code of the last finished array |
| fault | output | 1 | Pulse: trigger on a null descriptor |

## Verification
The bound checker watches several properties on every cycle:
- request fields stay stable under back-pressure;
- no request is presented while one is open;
- completion and chain pulses only follow a `req_done`;
- final and intermediate flags never occur together;
- a fault never coincides with a request.

Only the bench scenarios can show that the arithmetic is right. That covers address and count advance with signed strides, FIFO holding, frame-end reload, and link copy versus null versus static. The bench also shows how many requests each trigger produces in the two sync modes, and that pending triggers are merged. It checks all of this against its own model of the descriptor slots.

// File: rtl/sq_pkg.sv
package sq_pkg;
  typedef logic [31:0] word_t;
  localparam int DESC_WORDS = 8;
  localparam int W_OPT  = 0;
  localparam int W_SRC  = 1;
  localparam int W_AB   = 2;
  localparam int W_DST  = 3;
  localparam int W_BIDX = 4;
  localparam int W_LINK = 5;
  localparam int W_CIDX = 6;
  localparam int W_CC   = 7;
  localparam int OB_SFIFO = 0;
  localparam int OB_DFIFO = 1;
  localparam int OB_FRAME = 2;
  localparam int OB_STAT  = 3;
  localparam int OB_FIN_IRQ = 20;
  localparam int OB_MID_IRQ = 21;
  localparam int OB_FIN_CH  = 22;
  localparam int OB_MID_CH  = 23;
  localparam logic [15:0] NO_LINK = 16'hFFFF;

  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT} seq_st_e;

  function automatic word_t sext16(input logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  function automatic word_t null_word(input int w);
    return (w == W_LINK) ? {16'h0000, NO_LINK} : 32'h0;
  endfunction
endpackage

// File: rtl/sq_desc_store.sv
module sq_desc_store
  import sq_pkg::*;
#(
  parameter int NSLOT    = 8,
  parameter int ACT_SLOT = 0,
  localparam int SW      = $clog2(NSLOT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [SW-1:0] cfg_slot,
  input  logic [2:0]    cfg_word,
  input  word_t         cfg_wdata,
  input  logic          upd_we,
  input  word_t         upd_src,
  input  word_t         upd_dst,
  input  word_t         upd_ab,
  input  word_t         upd_cc,
  input  logic          ld_we,
  input  logic          ld_null,
  input  logic [SW-1:0] ld_slot,
  output word_t         act [DESC_WORDS]
);
  word_t mem [NSLOT][DESC_WORDS];

  // Later assignments take priority: reload over update over software write.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < NSLOT; s++)
        for (int w = 0; w < DESC_WORDS; w++)
          mem[s][w] <= '0;
    end else begin
      if (cfg_we) mem[cfg_slot][cfg_word] <= cfg_wdata;
      if (upd_we) begin
        mem[ACT_SLOT][W_SRC] <= upd_src;
        mem[ACT_SLOT][W_DST] <= upd_dst;
        mem[ACT_SLOT][W_AB]  <= upd_ab;
        mem[ACT_SLOT][W_CC]  <= upd_cc;
      end
      if (ld_we)
        for (int w = 0; w < DESC_WORDS; w++)
          mem[ACT_SLOT][w] <= ld_null ? null_word(w) : mem[ld_slot][w];
    end
  end

  for (genvar w = 0; w < DESC_WORDS; w++) begin : g_act
    assign act[w] = mem[ACT_SLOT][w];
  end
endmodule

// File: rtl/sq_advance.sv
module sq_advance
  import sq_pkg::*;
(
  input  logic  src_fifo,
  input  logic  dst_fifo,
  input  word_t src,
  input  word_t dst,
  input  word_t ab,
  input  word_t bidx,
  input  logic [15:0] b_reload,
  input  word_t cidx,
  input  word_t cc,
  output word_t n_src,
  output word_t n_dst,
  output word_t n_ab,
  output word_t n_cc,
  output logic  frame_end,
  output logic  final_arr,
  output logic  is_null
);
  logic [15:0] acnt, bcnt, ccnt;
  word_t src_step, dst_step;

  assign acnt = ab[15:0];
  assign bcnt = ab[31:16];
  assign ccnt = cc[15:0];

  assign frame_end = (bcnt == 16'd1);
  assign final_arr = frame_end && (ccnt == 16'd1);
  assign is_null   = (acnt == '0) || (bcnt == '0) || (ccnt == '0);

  assign src_step = frame_end ? sext16(cidx[15:0])  : sext16(bidx[15:0]);
  assign dst_step = frame_end ? sext16(cidx[31:16]) : sext16(bidx[31:16]);

  assign n_src = src_fifo ? src : src + src_step;
  assign n_dst = dst_fifo ? dst : dst + dst_step;
  assign n_ab  = {frame_end ? b_reload : bcnt - 16'd1, acnt};
  assign n_cc  = {cc[31:16], frame_end ? ccnt - 16'd1 : ccnt};
endmodule

// File: rtl/link_desc_seq.sv
module link_desc_seq
  import sq_pkg::*;
#(
  parameter int NSLOT    = 8,
  parameter int ACT_SLOT = 0,
  localparam int SW      = $clog2(NSLOT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trig,
  input  logic          cfg_we,
  input  logic [SW+2:0] cfg_addr,
  input  logic [31:0]   cfg_wdata,
  output logic          req_valid,
  input  logic          req_ready,
  output logic [31:0]   req_src,
  output logic [31:0]   req_dst,
  output logic [15:0]   req_bytes,
  input  logic          req_done,
  output logic          fin_irq,
  output logic          mid_irq,
  output logic          chain_go,
  output logic [5:0]    evt_code,
  output logic          fault
);
  word_t   act [DESC_WORDS];
  word_t   n_src, n_dst, n_ab, n_cc;
  logic    frame_end, final_arr, is_null;
  logic    pend, done_now, upd_we, ld_we;
  seq_st_e st;
  word_t   opt;

  assign opt      = act[W_OPT];
  assign done_now = (st == ST_WAIT) && req_done;
  assign upd_we   = done_now && !final_arr;
  assign ld_we    = done_now && final_arr && !opt[OB_STAT];

  sq_desc_store #(.NSLOT(NSLOT), .ACT_SLOT(ACT_SLOT)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_slot (cfg_addr[SW+2:3]),
    .cfg_word (cfg_addr[2:0]),
    .cfg_wdata(cfg_wdata),
    .upd_we   (upd_we),
    .upd_src  (n_src),
    .upd_dst  (n_dst),
    .upd_ab   (n_ab),
    .upd_cc   (n_cc),
    .ld_we    (ld_we),
    .ld_null  (act[W_LINK][15:0] == NO_LINK),
    .ld_slot  (act[W_LINK][SW-1:0]),
    .act      (act)
  );

  sq_advance u_adv (
    .src_fifo (opt[OB_SFIFO]),
    .dst_fifo (opt[OB_DFIFO]),
    .src      (act[W_SRC]),
    .dst      (act[W_DST]),
    .ab       (act[W_AB]),
    .bidx     (act[W_BIDX]),
    .b_reload (act[W_LINK][31:16]),
    .cidx     (act[W_CIDX]),
    .cc       (act[W_CC]),
    .n_src    (n_src),
    .n_dst    (n_dst),
    .n_ab     (n_ab),
    .n_cc     (n_cc),
    .frame_end(frame_end),
    .final_arr(final_arr),
    .is_null  (is_null)
  );

  assign req_valid = (st == ST_ISSUE);
  assign req_src   = act[W_SRC];
  assign req_dst   = act[W_DST];
  assign req_bytes = act[W_AB][15:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      pend     <= 1'b0;
      fin_irq  <= 1'b0;
      mid_irq  <= 1'b0;
      chain_go <= 1'b0;
      fault    <= 1'b0;
      evt_code <= '0;
    end else begin
      fin_irq  <= 1'b0;
      mid_irq  <= 1'b0;
      chain_go <= 1'b0;
      fault    <= 1'b0;
      if (trig && st != ST_IDLE) pend <= 1'b1;
      case (st)
        ST_IDLE: begin
          if (trig || pend) begin
            pend <= 1'b0;
            if (is_null) fault <= 1'b1;
            else         st    <= ST_ISSUE;
          end
        end
        ST_ISSUE: if (req_ready) st <= ST_WAIT;
        ST_WAIT: begin
          if (req_done) begin
            evt_code <= opt[17:12];
            if (final_arr) begin
              fin_irq  <= opt[OB_FIN_IRQ];
              chain_go <= opt[OB_FIN_CH];
              st       <= ST_IDLE;
            end else if (!opt[OB_FRAME] || frame_end) begin
              mid_irq  <= opt[OB_MID_IRQ];
              chain_go <= opt[OB_MID_CH];
              st       <= ST_IDLE;
            end else begin
              st <= ST_ISSUE;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sq_chk.sv
module sq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        req_done,
  input logic [31:0] req_src,
  input logic [31:0] req_dst,
  input logic [15:0] req_bytes,
  input logic        fin_irq,
  input logic        mid_irq,
  input logic        chain_go,
  input logic        fault
);
  logic open_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    open_req <= 1'b0;
    else if (req_valid && req_ready) open_req <= 1'b1;
    else if (req_done)             open_req <= 1'b0;
  end

  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_src) && $stable(req_dst) && $stable(req_bytes));

  // R3
  single_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    open_req |-> !req_valid);

  // R7
  pulse_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fin_irq || mid_irq || chain_go) |-> $past(req_done));

  // R7
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(fin_irq && mid_irq));

  // R10
  fault_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> !req_valid && !open_req);
endmodule

bind link_desc_seq sq_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .req_done (req_done),
  .req_src  (req_src),
  .req_dst  (req_dst),
  .req_bytes(req_bytes),
  .fin_irq  (fin_irq),
  .mid_irq  (mid_irq),
  .chain_go (chain_go),
  .fault    (fault)
);

// File: tb/link_desc_seq_test.sv
module link_desc_seq_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trig = 1'b0, cfg_we = 1'b0, req_ready = 1'b0, req_done = 1'b0;
  logic [5:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        req_valid, fin_irq, mid_irq, chain_go, fault;
  logic [31:0] req_src, req_dst;
  logic [15:0] req_bytes;
  logic [5:0]  evt_code;

  logic [31:0] m [8][8];
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  link_desc_seq uut (
    .clk(clk), .rst_n(rst_n), .trig(trig), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_ready(req_ready),
    .req_src(req_src), .req_dst(req_dst), .req_bytes(req_bytes), .req_done(req_done),
    .fin_irq(fin_irq), .mid_irq(mid_irq), .chain_go(chain_go), .evt_code(evt_code),
    .fault(fault)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] sx(input logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  function automatic bit m_null();
    return m[0][2][15:0] == 0 || m[0][2][31:16] == 0 || m[0][7][15:0] == 0;
  endfunction

  task automatic push_slot(input logic [2:0] s);
    for (int w = 0; w < 8; w++) begin
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = {s, 3'(w)}; cfg_wdata = m[s][w];
    end
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic gen_slot(input int s);
    logic [31:0] opt;
    opt = $urandom & 32'h00F3_F007;
    if ($urandom % 6 == 0) opt[3] = 1'b1;
    m[s][0] = opt;
    m[s][1] = $urandom;
    m[s][2] = {16'(1 + $urandom % 3), 16'(1 + $urandom % 300)};
    m[s][3] = $urandom;
    m[s][4] = $urandom;
    m[s][5] = {16'(1 + $urandom % 3), ($urandom % 4 == 0) ? 16'hFFFF : 16'($urandom % 8)};
    m[s][6] = $urandom;
    m[s][7] = {16'($urandom), 16'(1 + $urandom % 3)};
  endtask

  // Serve one array request; unit_end reports whether the trigger's unit finished.
  task automatic serve_one(input bit extra, output bit unit_end);
    logic [31:0] opt, t [8];
    logic [15:0] b, c;
    bit fin;
    int wt = 0;
    while (!req_valid && wt < 40) begin @(negedge clk); wt++; end
    chk("R2 valid", {31'b0, req_valid}, 1);
    chk("R2 src", req_src, m[0][1]);
    chk("R2 dst", req_dst, m[0][3]);
    chk("R2 bytes", {16'b0, req_bytes}, {16'b0, m[0][2][15:0]});
    repeat ($urandom % 3) begin
      @(negedge clk);
      chk("R2 hold src", req_src, m[0][1]);
    end
    req_ready = 1'b1;
    @(negedge clk);
    req_ready = 1'b0;
    chk("R3 no second request", {31'b0, req_valid}, 0);
    if (extra) begin
      trig = 1'b1; repeat (2) @(negedge clk); trig = 1'b0;
    end
    repeat ($urandom % 3) @(negedge clk);
    req_done = 1'b1;
    @(negedge clk);
    req_done = 1'b0;
    opt = m[0][0];
    b = m[0][2][31:16]; c = m[0][7][15:0];
    fin = (b == 1) && (c == 1);
    unit_end = !opt[2] || b == 1;
    chk("R7 code", {26'b0, evt_code}, {26'b0, opt[17:12]});
    chk("R7 fin_irq", {31'b0, fin_irq}, {31'b0, fin & opt[20]});
    chk("R7 mid_irq", {31'b0, mid_irq}, {31'b0, !fin & unit_end & opt[21]});
    chk("R7 chain", {31'b0, chain_go}, {31'b0, fin ? opt[22] : (unit_end & opt[23])});
    if (fin) begin
      if (!opt[3]) begin
        if (m[0][5][15:0] == 16'hFFFF)
          for (int w = 0; w < 8; w++) t[w] = (w == 5) ? 32'h0000FFFF : 32'h0;
        else
          for (int w = 0; w < 8; w++) t[w] = m[m[0][5][2:0]][w];
        for (int w = 0; w < 8; w++) m[0][w] = t[w];
      end
    end else if (b > 1) begin
      m[0][2][31:16] = b - 1;
      if (!opt[0]) m[0][1] = m[0][1] + sx(m[0][4][15:0]);
      if (!opt[1]) m[0][3] = m[0][3] + sx(m[0][4][31:16]);
    end else begin
      m[0][7][15:0]  = c - 1;
      m[0][2][31:16] = m[0][5][31:16];
      if (!opt[0]) m[0][1] = m[0][1] + sx(m[0][6][15:0]);
      if (!opt[1]) m[0][3] = m[0][3] + sx(m[0][6][31:16]);
    end
  endtask

  task automatic unit_run(input bit extra);
    bit ue;
    bit first = 1'b1;
    do begin
      serve_one(extra && first, ue);
      first = 1'b0;
    end while (!ue);
  endtask

  task automatic fire(input bit extra);
    trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
    if (m_null()) begin
      chk("R10 fault", {31'b0, fault}, 1);
      chk("R10 no request", {31'b0, req_valid}, 0);
      return;
    end
    unit_run(extra);
    if (extra) begin
      if (m_null()) begin
        @(negedge clk);
        chk("R10 pending fault", {31'b0, fault}, 1);
      end else begin
        unit_run(1'b0);
      end
    end
    repeat (3) @(negedge clk);
    chk("R3 merged triggers idle", {31'b0, req_valid}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int s = 0; s < 8; s++) for (int w = 0; w < 8; w++) m[s][w] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 valid", {31'b0, req_valid}, 0);
    chk("R1 pulses", {28'b0, fin_irq, mid_irq, chain_go, fault}, 0);
    // R10 trigger on the empty slot after reset
    fire(1'b0);

    // R4 R5 R6 R8 R11: array mode, fixed source, negative strides, link to slot 2
    m[0] = '{32'h0030_5001, 32'h1000, {16'd2, 16'd4}, 32'h8000,
             {16'hFFF0, 16'd4}, {16'd2, 16'd2}, {16'hFF00, 16'h0040}, 32'd2};
    m[2] = '{32'h0050_2004, 32'h2000, {16'd3, 16'd8}, 32'h9000,
             {16'd8, 16'd8}, {16'd3, 16'hFFFF}, {16'd100, 16'd100}, 32'd2};
    push_slot(3'd2);
    push_slot(3'd0);
    repeat (4) fire(1'b0);
    // R4 frame mode from the reloaded slot, then R10 null after no-link
    repeat (2) fire(1'b0);
    fire(1'b0);
    // R9 static descriptor: final array repeats
    m[0] = '{32'h0020_0008, 32'h40, {16'd1, 16'd16}, 32'h80,
             32'h0, {16'd1, 16'd3}, 32'h0, 32'd1};
    push_slot(3'd0);
    repeat (3) fire(1'b0);
    // R3 pending trigger during an open request
    m[0] = '{32'h00C0_1000, 32'h500, {16'd2, 16'd2}, 32'h600,
             {16'd2, 16'd2}, {16'd2, 16'd0}, 32'h0, 32'd3};
    push_slot(3'd0);
    fire(1'b1);
    fire(1'b1);

    // random rounds
    for (int r = 0; r < 40; r++) begin
      for (int s = 7; s >= 0; s--) begin
        gen_slot(s);
        push_slot(3'(s));
      end
      for (int k = 0; k < 6; k++) fire($urandom % 4 == 0);
    end

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule